// File: doc/BRIEF.md
# Lookahead Sum-Select Adder

This block is a purely combinational 32-bit adder meant to sit at the core of an ALU datapath. It takes two operands and a carry input and returns a 33-bit result whose top bit is the carry-out. No clock or storage element lies on the path, and the full result settles within a single evaluation.

Inside, the operands are cut into eight 4-bit groups. Each group works out its own generate and propagate terms. It also forms two candidate sums, one for an incoming carry of 0 and one for an incoming carry of 1. A two-level lookahead network turns the group generate and propagate terms into the carry that enters every group. A final selection stage then takes, for each group, the candidate that matches its lookahead carry.

The carry input lets an enclosing ALU subtract: it inverts one operand and sets the carry input to 1.

Top module: `lsa_adder`

## Requirements
- R1: For any operands and carry input, `sum_out` equals the 33-bit value `op_a + op_b + carry_in`.
- R2: `sum_out[32]` is the carry out of bit 31, and `sum_out[31:0]` is the low 32 bits of the total.
- R3: `carry_in` adds one at bit 0. With `op_b` set to the bitwise inverse of a value x and `carry_in` = 1, `sum_out[31:0]` equals `op_a - x` modulo 2^32, and `sum_out[32]` is 1 exactly when `op_a >= x`.
- R4: A carry that rises at bit 0 propagates through every group boundary within one evaluation. `0xFFFFFFFF + 0x00000001` with `carry_in` = 0 gives `sum_out` = `0x1_00000000`.
- R5: Every 4-bit group (bits 4k+3..4k) shows the sum that matches the true carry into bit 4k. An operand whose low 4k bits are all ones, plus 1, gives exactly 2^(4k) for every k from 1 to 8.
- R6: Zero plus zero with `carry_in` = 0 gives `sum_out` = 0. With `carry_in` = 1 it gives 1.
- R7: Alternating patterns produce no carry. `0xAAAAAAAA + 0x55555555` gives `0x0_FFFFFFFF`. With `carry_in` = 1 it gives `0x1_00000000`.
- R8: The output follows an input change with no clock edge in between. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 33 | Sum; bit 32 is the carry-out |

## Verification
The bench aims at carries that must cross group boundaries. A selection stage that used the wrong candidate, or a lookahead term that dropped a propagate factor, would leave one group's nibble off by one. The all-ones-plus-one case and the per-boundary walk would expose such an error. Alternating patterns make every bit propagate and none generate, so a network that invented a generate term would show a spurious carry there. Subtraction pairs test the carry input and the borrow meaning of the carry-out. A design that ignored `carry_in` would be off by one on every pair.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned LSA_DATA_W   = 32;
  localparam int unsigned LSA_GRP_W    = 4;
  localparam int unsigned LSA_BLK_GRPS = 4;
endpackage

// File: rtl/csel_group.sv
// One group: generate/propagate terms plus both candidate sums.
module csel_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         g,
  output logic         p,
  output logic [W-1:0] sum_c0,
  output logic [W-1:0] sum_c1
);
  function automatic logic [W:0] slice_add(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W:0] res0, res1;

  always_comb begin
    res0   = slice_add(a, b, 1'b0);
    res1   = slice_add(a, b, 1'b1);
    sum_c0 = res0[W-1:0];
    sum_c1 = res1[W-1:0];
    g      = res0[W];
    p      = &(a ^ b);
  end
endmodule

// File: rtl/cla_lookahead.sv
// Expanded sum-of-products lookahead over N positions.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] carry,
  output logic         blk_g,
  output logic         blk_p
);
  // Carry entering position j, written as a flat OR of AND terms.
  function automatic logic span_carry(input logic [N-1:0] gv,
                                      input logic [N-1:0] pv,
                                      input logic c,
                                      input int unsigned j);
    logic acc, term, thru;
    thru = c;
    acc  = 1'b0;
    for (int k = 0; k < N; k++)
      if (k < j) thru = thru & pv[k];
    for (int i = 0; i < N; i++) begin
      if (i < j) begin
        term = gv[i];
        for (int k = 0; k < N; k++)
          if (k > i && k < j) term = term & pv[k];
        acc = acc | term;
      end
    end
    return acc | thru;
  endfunction

  for (genvar j = 0; j < N; j++) begin : g_pos
    assign carry[j] = span_carry(g, p, cin, j);
  end

  assign blk_g = span_carry(g, p, 1'b0, N);
  assign blk_p = &p;
endmodule

// File: rtl/cla_tree.sv
// Two-level lookahead: group terms -> block terms -> block carries -> group carries.
module cla_tree #(
  parameter int unsigned NG = 8,
  parameter int unsigned BG = 4
) (
  input  logic [NG-1:0] g,
  input  logic [NG-1:0] p,
  input  logic          cin,
  output logic [NG:0]   grp_carry
);
  localparam int unsigned NB = NG / BG;

  logic [NB-1:0] blk_g, blk_p, blk_c;
  logic          top_g, top_p;

  for (genvar b = 0; b < NB; b++) begin : g_blk
    cla_lookahead #(.N(BG)) u_l1 (
      .g     (g[b*BG +: BG]),
      .p     (p[b*BG +: BG]),
      .cin   (blk_c[b]),
      .carry (grp_carry[b*BG +: BG]),
      .blk_g (blk_g[b]),
      .blk_p (blk_p[b])
    );
  end

  cla_lookahead #(.N(NB)) u_l2 (
    .g     (blk_g),
    .p     (blk_p),
    .cin   (cin),
    .carry (blk_c),
    .blk_g (top_g),
    .blk_p (top_p)
  );

  assign grp_carry[NG] = top_g | (top_p & cin);
endmodule

// File: rtl/lsa_adder.sv
module lsa_adder #(
  parameter int unsigned DATA_W   = lsa_pkg::LSA_DATA_W,
  parameter int unsigned GRP_W    = lsa_pkg::LSA_GRP_W,
  parameter int unsigned BLK_GRPS = lsa_pkg::LSA_BLK_GRPS
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              carry_in,
  output logic [DATA_W:0]   sum_out
);
  localparam int unsigned NG = DATA_W / GRP_W;

  logic [NG-1:0]            grp_gen, grp_prop;
  logic [NG:0]              grp_carry;
  logic [NG-1:0][GRP_W-1:0] sum_c0, sum_c1;
  logic [DATA_W-1:0]        sum_sel;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    csel_group #(.W(GRP_W)) u_grp (
      .a      (op_a[k*GRP_W +: GRP_W]),
      .b      (op_b[k*GRP_W +: GRP_W]),
      .g      (grp_gen[k]),
      .p      (grp_prop[k]),
      .sum_c0 (sum_c0[k]),
      .sum_c1 (sum_c1[k])
    );
    assign sum_sel[k*GRP_W +: GRP_W] = grp_carry[k] ? sum_c1[k] : sum_c0[k];
  end

  cla_tree #(.NG(NG), .BG(BLK_GRPS)) u_tree (
    .g         (grp_gen),
    .p         (grp_prop),
    .cin       (carry_in),
    .grp_carry (grp_carry)
  );

  assign sum_out = {grp_carry[NG], sum_sel};
endmodule

// File: rtl/lsa_adder_chk.sv
module lsa_adder_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GRP_W  = 4
) (
  input logic [DATA_W-1:0]                op_a,
  input logic [DATA_W-1:0]                op_b,
  input logic                             carry_in,
  input logic [DATA_W:0]                  sum_out,
  input logic [DATA_W/GRP_W-1:0]          grp_gen,
  input logic [DATA_W/GRP_W-1:0]          grp_prop,
  input logic [DATA_W/GRP_W:0]            grp_carry,
  input logic [DATA_W/GRP_W-1:0][GRP_W-1:0] sum_c0,
  input logic [DATA_W/GRP_W-1:0][GRP_W-1:0] sum_c1
);
  localparam int unsigned NG = DATA_W / GRP_W;

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      p_sum_exact_r1: assert (sum_out == ({1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in}))
        else $error("R1 sum mismatch");
      p_cout_r2: assert (sum_out[DATA_W] == grp_carry[NG])
        else $error("R2 carry-out differs from last group carry");
      p_cin_entry_r3: assert (grp_carry[0] == carry_in)
        else $error("R3 carry into group 0 differs from carry_in");
      for (int k = 0; k < NG; k++) begin
        p_carry_chain_r4: assert (grp_carry[k+1] == (grp_gen[k] | (grp_prop[k] & grp_carry[k])))
          else $error("R4 lookahead carry wrong at group %0d", k);
        p_pair_offset_r5: assert (sum_c1[k] == sum_c0[k] + GRP_W'(1))
          else $error("R5 candidate pair inconsistent at group %0d", k);
      end
    end
  end
endmodule

bind lsa_adder lsa_adder_chk #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .grp_gen   (grp_gen),
  .grp_prop  (grp_prop),
  .grp_carry (grp_carry),
  .sum_c0    (sum_c0),
  .sum_c1    (sum_c1)
);

// File: tb/lsa_adder_tb.sv
module lsa_adder_tb;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [32:0] sum_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsa_adder u_dut (.op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sum_out(sum_out));

  task automatic compare(input string req, input logic [32:0] exp);
    checks++;
    if (sum_out !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, op_a, op_b, carry_in, sum_out, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic c, input logic [32:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    #1;
    compare(req, exp);
  endtask

  task automatic t_zero();  // R6
    apply("R6", 32'h0, 32'h0, 1'b0, 33'h0);
    apply("R6", 32'h0, 32'h0, 1'b1, 33'h1);
  endtask

  task automatic t_all_ones();  // R4, R2
    apply("R4", 32'hFFFF_FFFF, 32'h1, 1'b0, 33'h1_0000_0000);
    apply("R2", 32'hFFFF_FFFF, 32'h0, 1'b1, 33'h1_0000_0000);
    apply("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF);
  endtask

  task automatic t_alternating();  // R7
    apply("R7", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF);
    apply("R7", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000);
    apply("R7", 32'h5555_5555, 32'h5555_5555, 1'b0, 33'h0_AAAA_AAAA);
  endtask

  task automatic t_subtract();  // R3
    logic [31:0] xs [4] = '{32'd5, 32'd9, 32'h8000_0000, 32'd0};
    logic [31:0] as [4] = '{32'd9, 32'd5, 32'h8000_0000, 32'd7};
    for (int i = 0; i < 4; i++) begin
      logic [32:0] exp;
      exp = {(as[i] >= xs[i]) ? 1'b1 : 1'b0, as[i] - xs[i]};
      apply("R3", as[i], ~xs[i], 1'b1, exp);
    end
  endtask

  task automatic t_boundaries();  // R5
    for (int k = 1; k <= 8; k++) begin
      logic [32:0] ones;
      ones = (33'h1 << (4*k)) - 33'h1;
      apply("R5", ones[31:0], 32'h1, 1'b0, 33'h1 << (4*k));
    end
  endtask

  task automatic t_random();  // R1
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      logic c;
      a = $urandom; b = $urandom; c = 1'($urandom);
      apply("R1", a, b, c, {1'b0, a} + {1'b0, b} + {32'h0, c});
    end
  endtask

  task automatic t_no_clock();  // R8
    @(posedge clk);
    #0.5;
    op_a = 32'h1234_5678; op_b = 32'h1111_1111; carry_in = 1'b0;
    #0.5;
    compare("R8", 33'h0_2345_6789);
    op_b = 32'hEDCB_A988;
    #0.5;
    compare("R8", 33'h1_0000_0000);
  endtask

  initial begin
    #1;
    compare("R6", 33'h0);
    t_zero();
    t_all_ones();
    t_alternating();
    t_subtract();
    t_boundaries();
    t_random();
    t_no_clock();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule